// File: doc/BRIEF.md
# Display Link Rate and Lane Count Selector

This block chooses how a display stream is carried over a multi-lane serial link. It takes the requested pixel clock in kHz, the colour depth in bits per component and the sink's two capability bytes: its highest link-rate code and its lane-count byte. It returns the lane count, the per-lane link rate in kHz and a flag that says whether the mode can be driven. Two further inputs give the sink's support for the 1.2 high rate and a bridge override that pins the rate.

The search favours narrow, slow links. It settles the lane count first, assuming the sink's top rate. It then picks the slowest rate that still carries the stream over that lane count. The fit test never divides. The pixel demand (pixel clock times bits per pixel) is formed by a shift-and-add multiplier over several cycles. Each candidate link capacity is a rate shifted left by the lane count's exponent plus three.

A request is launched with a one-cycle start pulse while the block is idle. `busy_o` stays high while the search runs. A one-cycle `done_o` pulse marks the new results, and they hold until the next request completes.

Top module: `link_cfg_select`

## Requirements
- R1: Bits per pixel are three times the bits per component, except that a component depth of 0 means 24 bits per pixel.
- R2: A rate r (kHz) with n lanes carries the stream when pixel_kHz × bpp ≤ r × n × 8, evaluated exactly in integers with no rounding.
- R3: Only the low 5 bits of the lane-count byte give the maximum lane count; the upper 3 bits are ignored. Lane counts 1, 2, 4, 8, … are tried at the sink's maximum rate while the count is below that maximum. The result is the first count that carries the stream. If none does, the result is the first power of two not below the maximum, which is 1 when the maximum is 0 or 1.
- R4: The rate code 0x06 means 162000 kHz, 0x0A means 270000 kHz and 0x14 means 540000 kHz. Any other code is taken as 162000 kHz.
- R5: With the chosen lane count, the rate is 162000 if it carries the stream, else 270000 if it carries it. Failing both, it is 540000 when the sink is 1.2-capable and 540000 carries the stream. Otherwise it is the sink's maximum rate.
- R6: When the bridge override is high, the rate is 270000 whatever the pixel clock; the lane count is still chosen as in R3.
- R7: `mode_ok_o` is low exactly when the chosen rate is 540000 and the sink is not 1.2-capable.
- R8: A start pulse taken while idle raises `busy_o` on the next cycle. Completion gives `done_o` high for exactly one cycle with `busy_o` low. The results change only on that cycle and hold until the next completion. A start pulse while busy is ignored.
- R9: After reset, `busy_o`, `done_o`, `lanes_o`, `rate_khz_o` and `mode_ok_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launches a request when idle |
| pix_khz_i | input | PIX_W | Requested pixel clock in kHz |
| bpc_i | input | BPC_W | Bits per colour component (0 = default 8) |
| max_rate_code_i | input | 8 | Sink's highest link-rate code |
| max_lane_byte_i | input | 8 | Sink's lane-count byte (low 5 bits used) |
| sink_v12_i | input | 1 | Sink supports the 540000 kHz rate |
| bridge_fix_i | input | 1 | Bridge override: force 270000 kHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| lanes_o | output | LANE_FIELD_W+1 | Chosen lane count |
| rate_khz_o | output | 20 | Chosen link rate in kHz |
| mode_ok_o | output | 1 | Mode can be driven |

## Verification
The hardest case to reach is the path where no listed rate carries the stream, so the sink's maximum is returned. Paired with a sink that is not 1.2-capable but advertises the 540000 code, this is the only way `mode_ok_o` goes low. The stimulus reaches it with a pixel demand that beats 270000 kHz on every lane count and a sink whose lane maximum stops the search. The same is done with a non-power-of-two lane maximum, which makes the search overshoot it. A start pulse is also injected in the middle of a running search, with different inputs, to show the results belong to the first request.

// File: rtl/link_cfg_pkg.sv
package link_cfg_pkg;
  localparam int unsigned RATE_W = 20;

  localparam logic [7:0] CODE_SLOW = 8'h06;
  localparam logic [7:0] CODE_MED  = 8'h0A;
  localparam logic [7:0] CODE_FAST = 8'h14;

  localparam logic [RATE_W-1:0] KHZ_SLOW = 20'd162000;
  localparam logic [RATE_W-1:0] KHZ_MED  = 20'd270000;
  localparam logic [RATE_W-1:0] KHZ_FAST = 20'd540000;

  typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_LANE, ST_RATE} sel_state_t;

  // rate code to kHz; unknown codes fall back to the slowest rate
  function automatic logic [RATE_W-1:0] code_to_khz(input logic [7:0] code);
    logic [RATE_W-1:0] khz;
    case (code)
      CODE_MED:  khz = KHZ_MED;
      CODE_FAST: khz = KHZ_FAST;
      default:   khz = KHZ_SLOW;
    endcase
    return khz;
  endfunction
endpackage

// File: rtl/link_cfg_mult.sv
// Sequential shift-and-add multiplier: one multiplier bit per cycle.
module link_cfg_mult #(
  parameter int unsigned A_W = 20,
  parameter int unsigned B_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [A_W-1:0]     a,
  input  logic [B_W-1:0]     b,
  output logic [A_W+B_W-1:0] prod,
  output logic               fin
);
  localparam int unsigned P_W   = A_W + B_W;
  localparam int unsigned CNT_W = $clog2(B_W + 1);

  logic [P_W-1:0]   a_sh;
  logic [B_W-1:0]   b_sh;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [A_W-1:0]   a_q;
  logic [B_W-1:0]   b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sh <= '0;
      b_sh <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      prod <= '0;
      fin  <= 1'b0;
      a_q  <= '0;
      b_q  <= '0;
    end else begin
      fin <= 1'b0;
      if (go && !run) begin
        a_sh <= P_W'(a);
        b_sh <= b;
        a_q  <= a;
        b_q  <= b;
        prod <= '0;
        cnt  <= CNT_W'(B_W);
        run  <= 1'b1;
      end else if (run) begin
        if (b_sh[0]) prod <= prod + a_sh;
        a_sh <= a_sh << 1;
        b_sh <= b_sh >> 1;
        cnt  <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  // R2: the product presented with fin is the exact product of the operands
  a_r2_product: assert property (@(posedge clk) disable iff (rst)
    fin |-> (prod == P_W'(a_q) * P_W'(b_q)));
endmodule

// File: rtl/link_cfg_fit.sv
// Capacity test: demand <= rate * 2^shift * 8, without division.
module link_cfg_fit #(
  parameter int unsigned RATE_W = 20,
  parameter int unsigned SH_W   = 3,
  parameter int unsigned CMP_W  = 32
) (
  input  logic [RATE_W-1:0] rate,
  input  logic [SH_W-1:0]   shift,
  input  logic [CMP_W-1:0]  demand,
  output logic              fits
);
  logic [CMP_W-1:0] cap;

  always_comb begin
    cap  = (CMP_W'(rate) << 3) << shift;
    fits = (demand <= cap);
  end
endmodule

// File: rtl/link_cfg_select.sv
module link_cfg_select
  import link_cfg_pkg::*;
#(
  parameter int unsigned PIX_W        = 20,
  parameter int unsigned BPC_W        = 4,
  parameter int unsigned LANE_FIELD_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [PIX_W-1:0]        pix_khz_i,
  input  logic [BPC_W-1:0]        bpc_i,
  input  logic [7:0]              max_rate_code_i,
  input  logic [7:0]              max_lane_byte_i,
  input  logic                    sink_v12_i,
  input  logic                    bridge_fix_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [LANE_FIELD_W:0]   lanes_o,
  output logic [19:0]             rate_khz_o,
  output logic                    mode_ok_o
);
  localparam int unsigned BPP_W  = BPC_W + 2;
  localparam int unsigned LANE_W = LANE_FIELD_W + 1;
  localparam int unsigned SH_W   = $clog2(LANE_FIELD_W + 1);
  localparam int unsigned PROD_W = PIX_W + BPP_W;
  localparam int unsigned CAP_W  = RATE_W + LANE_FIELD_W + 3;
  localparam int unsigned CMP_W  = (PROD_W > CAP_W) ? PROD_W : CAP_W;
  localparam int unsigned N_CAND = 4;

  sel_state_t             state;
  logic [RATE_W-1:0]      max_rate_q;
  logic [LANE_FIELD_W-1:0] max_lanes_q;
  logic                   v12_q;
  logic                   bridge_q;
  logic [CMP_W-1:0]       demand_q;
  logic [SH_W-1:0]        shift_q;
  logic [BPP_W-1:0]       bpp;
  logic [PROD_W-1:0]      mul_prod;
  logic                   mul_fin;
  logic                   accept;
  logic [LANE_W-1:0]      lane_cur;
  logic [RATE_W-1:0]      cand [N_CAND];
  logic [N_CAND-1:0]      fit;
  logic [RATE_W-1:0]      rate_pick;

  assign accept   = start_i && (state == ST_IDLE);
  assign lane_cur = LANE_W'(1) << shift_q;

  // R1: bits per pixel from component depth
  always_comb begin
    if (bpc_i == '0) bpp = BPP_W'(24);
    else             bpp = BPP_W'(3) * BPP_W'(bpc_i);
  end

  link_cfg_mult #(.A_W(PIX_W), .B_W(BPP_W)) u_mult (
    .clk  (clk),
    .rst  (rst),
    .go   (accept),
    .a    (pix_khz_i),
    .b    (bpp),
    .prod (mul_prod),
    .fin  (mul_fin)
  );

  // candidate rates: sink maximum, then the three fixed rates
  always_comb begin
    cand[0] = max_rate_q;
    cand[1] = KHZ_SLOW;
    cand[2] = KHZ_MED;
    cand[3] = KHZ_FAST;
  end

  for (genvar k = 0; k < N_CAND; k++) begin : g_fit
    link_cfg_fit #(.RATE_W(RATE_W), .SH_W(SH_W), .CMP_W(CMP_W)) u_fit (
      .rate   (cand[k]),
      .shift  (shift_q),
      .demand (demand_q),
      .fits   (fit[k])
    );
  end

  // R5/R6: rate priority for the chosen lane count
  always_comb begin
    if (bridge_q)              rate_pick = KHZ_MED;
    else if (fit[1])           rate_pick = KHZ_SLOW;
    else if (fit[2])           rate_pick = KHZ_MED;
    else if (v12_q && fit[3])  rate_pick = KHZ_FAST;
    else                       rate_pick = max_rate_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      max_rate_q  <= '0;
      max_lanes_q <= '0;
      v12_q       <= 1'b0;
      bridge_q    <= 1'b0;
      demand_q    <= '0;
      shift_q     <= '0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      lanes_o     <= '0;
      rate_khz_o  <= '0;
      mode_ok_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            max_rate_q  <= code_to_khz(max_rate_code_i);
            max_lanes_q <= max_lane_byte_i[LANE_FIELD_W-1:0];
            v12_q       <= sink_v12_i;
            bridge_q    <= bridge_fix_i;
            busy_o      <= 1'b1;
            state       <= ST_MUL;
          end
        end
        ST_MUL: begin
          if (mul_fin) begin
            demand_q <= CMP_W'(mul_prod);
            shift_q  <= '0;
            state    <= ST_LANE;
          end
        end
        ST_LANE: begin
          // R3: widen while below the sink maximum and not fitting at max rate
          if ((lane_cur < LANE_W'(max_lanes_q)) && !fit[0]) shift_q <= shift_q + 1'b1;
          else                                              state   <= ST_RATE;
        end
        ST_RATE: begin
          lanes_o    <= lane_cur;
          rate_khz_o <= rate_pick;
          mode_ok_o  <= !((rate_pick == KHZ_FAST) && !v12_q);
          busy_o     <= 1'b0;
          done_o     <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R8: completion never coincides with busy
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  // R8: results hold while idle
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> ($stable(lanes_o) && $stable(rate_khz_o) && $stable(mode_ok_o)));
  // R3: the lane count is a power of two
  a_r3_pow2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($countones(lanes_o) == 1));
  // R5: only the three listed rates are produced
  a_r5_rate_legal: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (rate_khz_o == KHZ_SLOW || rate_khz_o == KHZ_MED || rate_khz_o == KHZ_FAST));
  // R7: any rate below the top one is always a valid mode
  a_r7_low_rate_ok: assert property (@(posedge clk) disable iff (rst)
    (done_o && rate_khz_o != KHZ_FAST) |-> mode_ok_o);
  // R6: the bridge override pins the rate
  a_r6_bridge: assert property (@(posedge clk) disable iff (rst)
    (done_o && bridge_q) |-> (rate_khz_o == KHZ_MED));
endmodule

// File: tb/link_cfg_select_tb_top.sv
`timescale 1ns/1ps
module link_cfg_select_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [19:0] pix_khz_i = '0;
  logic [3:0]  bpc_i = '0;
  logic [7:0]  max_rate_code_i = '0;
  logic [7:0]  max_lane_byte_i = '0;
  logic        sink_v12_i = 1'b0;
  logic        bridge_fix_i = 1'b0;
  logic        busy_o, done_o, mode_ok_o;
  logic [5:0]  lanes_o;
  logic [19:0] rate_khz_o;

  int checks = 0;
  int fails  = 0;
  int q_l[$], q_r[$], q_ok[$];
  string q_tag[$];
  int last_l = 0, last_r = 0, last_ok = 0;
  bit have_last = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  link_cfg_select dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .pix_khz_i(pix_khz_i), .bpc_i(bpc_i),
    .max_rate_code_i(max_rate_code_i), .max_lane_byte_i(max_lane_byte_i),
    .sink_v12_i(sink_v12_i), .bridge_fix_i(bridge_fix_i), .busy_o(busy_o),
    .done_o(done_o), .lanes_o(lanes_o), .rate_khz_o(rate_khz_o), .mode_ok_o(mode_ok_o));

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // behavioural reference from the requirements
  function automatic void model(input int pix, input int bpc, input int code, input int lb,
                                input bit v12, input bit br, output int l, output int r,
                                output int ok);
    longint bpp  = (bpc == 0) ? 24 : 3 * bpc;
    longint maxr = (code == 'h06) ? 162000 : (code == 'h0A) ? 270000 :
                   (code == 'h14) ? 540000 : 162000;
    int maxl = lb & 31;
    longint d = longint'(pix) * bpp;
    l = 1;
    while (l < maxl) begin
      if (d <= maxr * l * 8) break;
      l = l * 2;
    end
    if (br) r = 270000;
    else if (d <= 64'd162000 * l * 8) r = 162000;
    else if (d <= 64'd270000 * l * 8) r = 270000;
    else if (v12 && d <= 64'd540000 * l * 8) r = 540000;
    else r = int'(maxr);
    ok = (r == 540000 && !v12) ? 0 : 1;
  endfunction

  task automatic drive(input int pix, input int bpc, input int code, input int lb,
                       input bit v12, input bit br);
    pix_khz_i = 20'(pix); bpc_i = 4'(bpc); max_rate_code_i = 8'(code);
    max_lane_byte_i = 8'(lb); sink_v12_i = v12; bridge_fix_i = br;
  endtask

  task automatic req(input string tag, input int pix, input int bpc, input int code,
                     input int lb, input bit v12, input bit br, input bit poke);
    int l, r, ok, guard;
    model(pix, bpc, code, lb, v12, br, l, r, ok);
    @(negedge clk);
    drive(pix, bpc, code, lb, v12, br);
    q_l.push_back(l); q_r.push_back(r); q_ok.push_back(ok); q_tag.push_back(tag);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check({tag, " R8 busy after start"}, busy_o, 1);
    if (poke) begin
      // R8: a start while busy with other inputs must be ignored
      drive(1, 0, 'h14, 8'h1F, 1, 1);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (q_l.size() != 0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    if (q_l.size() != 0) begin
      fails++;
      $display("FAIL %s R8 no completion got 0 expected 1", tag);
      q_l.delete(); q_r.delete(); q_ok.delete(); q_tag.delete();
    end
    repeat (2) @(negedge clk);
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (done_o) begin
        check("R8 done with busy low", busy_o, 0);
        if (q_l.size() == 0) begin
          fails++; checks++;
          $display("FAIL R8 unexpected done got 1 expected 0");
        end else begin
          last_l = q_l.pop_front(); last_r = q_r.pop_front();
          last_ok = q_ok.pop_front();
          check({q_tag[0], " lanes"}, lanes_o, last_l);
          check({q_tag[0], " rate"}, rate_khz_o, last_r);
          check({q_tag[0], " R7 mode_ok"}, mode_ok_o, last_ok);
          void'(q_tag.pop_front());
          have_last = 1;
        end
      end else if (have_last) begin
        check("R8 hold lanes", lanes_o, last_l);
        check("R8 hold rate", rate_khz_o, last_r);
        check("R8 hold mode_ok", mode_ok_o, last_ok);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R9 busy", busy_o, 0);
    check("R9 done", done_o, 0);
    check("R9 lanes", lanes_o, 0);
    check("R9 rate", rate_khz_o, 0);
    check("R9 mode_ok", mode_ok_o, 0);
    rst = 1'b0;
    // R2 R3 R5: two lanes at 270000
    req("R2 R3 R5 two-lane", 148500, 8, 'h0A, 4, 0, 0, 0);
    // R1: depth 0 behaves as 24 bpp; single slow lane
    req("R1 R5 default depth", 25175, 0, 'h0A, 4, 0, 0, 0);
    // R2: exact boundary, 162000*8/24 = 54000 fits one lane at slowest rate
    req("R2 boundary fit", 54000, 8, 'h06, 4, 0, 0, 0);
    req("R2 boundary miss", 54001, 8, 'h06, 4, 0, 0, 0);
    // R4: unknown code treated as 162000; search stops at the lane maximum
    req("R4 R3 unknown code", 400000, 8, 'h33, 4, 0, 0, 0);
    // R5 R7: 1.2-capable sink uses 540000
    req("R5 R7 top rate capable", 533250, 10, 'h14, 4, 1, 0, 0);
    // R5 R7: not capable, falls back to sink maximum 540000, mode invalid
    req("R5 R7 top rate not capable", 533250, 10, 'h14, 4, 0, 0, 0);
    // R6: bridge pins 270000 even for a tiny pixel clock
    req("R6 bridge override", 25175, 8, 'h14, 4, 0, 1, 0);
    // R3: upper bits of the lane byte ignored
    req("R3 lane byte upper bits", 400000, 8, 'h0A, 8'hE2, 0, 0, 0);
    // R3: non-power-of-two maximum overshoots to 4
    req("R3 max three lanes", 500000, 12, 'h0A, 3, 0, 0, 0);
    // R3: maximum 0 gives one lane
    req("R3 max zero lanes", 500000, 12, 'h0A, 0, 0, 0, 0);
    // R8: a start during busy is ignored
    req("R8 start while busy", 148500, 8, 'h0A, 4, 0, 0, 1);
    // R1 R4 R5 sweep
    for (int i = 0; i < 40; i++) begin
      int codes[4] = '{'h06, 'h0A, 'h14, 'h51};
      req("R1 R3 R4 R5 R7 sweep", int'($urandom_range(1, 700000)), int'($urandom_range(0, 15)),
          codes[$urandom_range(0, 3)], int'($urandom_range(0, 255)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) == 0), 0);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule